// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs one management transaction at a time against an external PHY over the two-wire MDC/MDIO interface. The host gives a start pulse together with the read/write choice, the 5-bit PHY address, the 5-bit register address and, for writes, 16 bits of data. The block serialises the frame, generates MDC from the system clock at one of three rates, and returns read data with a one-cycle done strobe.

On reads the block checks that the PHY takes over the line during the second turnaround bit. If the PHY does not pull MDIO low there, the returned data is marked bad through a read-error flag. That flag drives an interrupt output only while the interrupt enable is set. The 32-bit run of ones that starts a frame can be skipped on request. A request that names the reserved PHY address 1Fh is refused without any bus activity.

The pad side is split into an MDC output and three MDIO signals: data out, output enable and data in. The output enable is meant to control an external tri-state buffer.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Whenever no transaction is running (after reset, between frames, after a refused request), `mdc` is 0 and `mdio_oe` is 0.
- R2: The bits of a write frame are driven MSB first, in this order: start bits `01`, opcode `01`, the 5 PHY address bits, the 5 register address bits, turnaround `10`, then the 16 data bits. Each bit is set up while MDC is low and held constant while MDC is high.
- R3: Unless `no_preamble` is 1 at start, the frame begins with 32 bit times driven to 1. With `no_preamble` = 1 the start bits come first.
- R4: A read frame drives exactly 14 bits after any preamble: `01`, opcode `10`, PHY address, register address. MDIO is released (`mdio_oe` = 0) from the first turnaround bit until the transaction ends.
- R5: On a read, the 16 data bits are sampled from `mdio_i` on the MDC rising edges, MSB first, and appear on `rd_data` when `done` is high.
- R6: If `mdio_i` is 1 at the MDC rise of the second turnaround bit of a read, `rd_err` is 1 from `done` onward. `irq` equals `rd_err` AND `irq_en` at all times. Both `rd_err` and `addr_err` are cleared when the next request is accepted.
- R7: `rate_sel` is captured at start and sets the MDC half period: 00 gives HALF_SLOW system clocks (20, for 2.5 MHz from 100 MHz), 01 gives HALF_MID (10), and 10 or 11 give HALF_FAST (5). A frame of N bit times ends with `done` exactly N x 2 x half clocks after the start edge, where N is 65 with the preamble and 33 without it. The last of those bit times is the idle bit with MDIO released.
- R8: A start with `phy_addr` = 1Fh produces no MDC edge. `done` and `addr_err` are 1 on the cycle after the start edge.
- R9: A `start` that arrives while a transaction is running is ignored. The running frame and its length are unchanged.
- R10: `done` is high for exactly one system clock per transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted only when idle |
| rd_wr | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Data for a write |
| no_preamble | input | 1 | 1 skips the 32-bit preamble |
| rate_sel | input | 2 | MDC rate select |
| irq_en | input | 1 | Read-error interrupt enable |
| rd_data | output | 16 | Data of the last completed read |
| done | output | 1 | One-cycle completion strobe |
| rd_err | output | 1 | Turnaround check failed on the last read |
| addr_err | output | 1 | Last request named the reserved address |
| irq | output | 1 | Masked read-error interrupt |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output data |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input data |

## Verification
The assertions assume that `start` is a clean pulse and that the request fields are stable in the cycle it is sampled. They also assume that `mdio_i` is always a known level, because a released line is taken to be pulled up. The bench's PHY model therefore drives `mdio_i` to 1 outside the turnaround and data bits. It changes the line only just after MDC rises, so every value is stable when it is sampled. Requests are applied between clock edges, and the request fields are held until the transaction completes.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PRE_BITS   = 32;
    localparam int FRAME_BITS = 32;
    localparam int LAST_POS   = PRE_BITS + FRAME_BITS;   // idle bit
    localparam int POS_W      = $clog2(LAST_POS + 1);
    localparam int TA2_POS    = PRE_BITS + 15;
    localparam int DATA_POS   = PRE_BITS + 16;

    localparam logic [4:0] RSVD_PHY = 5'h1F;

    typedef logic [POS_W-1:0]      pos_t;
    typedef logic [FRAME_BITS-1:0] frame_t;

    typedef enum logic [1:0] {
        OPC_WRITE = 2'b01,
        OPC_READ  = 2'b10
    } opcode_e;

    // Returns {output_enable, data} for a bit position of the frame.
    function automatic logic [1:0] bit_out(pos_t pos, frame_t frame, frame_t drive);
        logic [4:0] idx;
        if (pos < pos_t'(PRE_BITS)) begin
            return 2'b11;
        end else if (pos < pos_t'(LAST_POS)) begin
            idx = 5'(FRAME_BITS - 1) - 5'(pos - pos_t'(PRE_BITS));
            return {drive[idx], frame[idx]};
        end
        return 2'b01;
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int HALF_SLOW = 20,
    parameter int HALF_MID  = 10,
    parameter int HALF_FAST = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       mdc,
    output logic       rise,
    output logic       fall
);
    localparam int HMAX = (HALF_SLOW > HALF_MID) ?
                          ((HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST) :
                          ((HALF_MID > HALF_FAST) ? HALF_MID : HALF_FAST);
    localparam int CW = $clog2(HMAX + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } gen_t;

    gen_t          g_d, g_q;
    logic [CW-1:0] half;
    logic          wrap;

    always_comb begin
        case (rate)
            2'b00:   half = CW'(HALF_SLOW);
            2'b01:   half = CW'(HALF_MID);
            default: half = CW'(HALF_FAST);
        endcase
    end

    assign wrap = run && (g_q.cnt == half - CW'(1));
    assign rise = wrap && !g_q.mdc;
    assign fall = wrap && g_q.mdc;
    assign mdc  = g_q.mdc;

    always_comb begin
        g_d = g_q;
        if (!run) begin
            g_d.cnt = '0;
            g_d.mdc = 1'b0;
        end else if (wrap) begin
            g_d.cnt = '0;
            g_d.mdc = !g_q.mdc;
        end else begin
            g_d.cnt = g_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end
endmodule

// File: rtl/mdio_frame_build.sv
module mdio_frame_build
    import mdio_pkg::*;
(
    input  logic        is_read,
    input  logic [4:0]  phy,
    input  logic [4:0]  regad,
    input  logic [15:0] wdata,
    output frame_t      frame,
    output frame_t      drive
);
    always_comb begin
        if (is_read) begin
            frame = {2'b01, OPC_READ, phy, regad, 2'b11, 16'hFFFF};
            drive = {{14{1'b1}}, {(FRAME_BITS - 14){1'b0}}};
        end else begin
            frame = {2'b01, OPC_WRITE, phy, regad, 2'b10, wdata};
            drive = '1;
        end
    end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_pkg::*;
#(
    parameter int HALF_SLOW = 20,
    parameter int HALF_MID  = 10,
    parameter int HALF_FAST = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        rd_wr,
    input  logic [4:0]  phy_addr,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] wr_data,
    input  logic        no_preamble,
    input  logic [1:0]  rate_sel,
    input  logic        irq_en,
    output logic [15:0] rd_data,
    output logic        done,
    output logic        rd_err,
    output logic        addr_err,
    output logic        irq,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    typedef struct packed {
        logic        busy;
        logic        is_read;
        pos_t        pos;
        frame_t      frame;
        frame_t      drive;
        logic [1:0]  rate;
        logic [15:0] shin;
        logic        ta_bad;
        logic [15:0] rd_data;
        logic        rd_err;
        logic        addr_err;
        logic        done;
        logic        mdio_o;
        logic        mdio_oe;
    } state_t;

    state_t st_d, st_q;
    frame_t new_frame, new_drive;
    logic   tick_rise, tick_fall;
    logic   busy_w;

    mdio_mdc_gen #(
        .HALF_SLOW (HALF_SLOW),
        .HALF_MID  (HALF_MID),
        .HALF_FAST (HALF_FAST)
    ) u_mdc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q.busy),
        .rate  (st_q.rate),
        .mdc   (mdc),
        .rise  (tick_rise),
        .fall  (tick_fall)
    );

    mdio_frame_build u_build (
        .is_read (rd_wr),
        .phy     (phy_addr),
        .regad   (reg_addr),
        .wdata   (wr_data),
        .frame   (new_frame),
        .drive   (new_drive)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.rd_err   = 1'b0;
                st_d.addr_err = 1'b0;
                if (phy_addr == RSVD_PHY) begin
                    st_d.addr_err = 1'b1;
                    st_d.done     = 1'b1;
                end else begin
                    st_d.busy    = 1'b1;
                    st_d.is_read = rd_wr;
                    st_d.pos     = no_preamble ? pos_t'(PRE_BITS) : '0;
                    st_d.frame   = new_frame;
                    st_d.drive   = new_drive;
                    st_d.rate    = rate_sel;
                    st_d.ta_bad  = 1'b0;
                end
            end
        end else begin
            if (tick_rise && st_q.is_read) begin
                if (st_q.pos == pos_t'(TA2_POS))
                    st_d.ta_bad = mdio_i;
                if (st_q.pos >= pos_t'(DATA_POS) && st_q.pos < pos_t'(LAST_POS))
                    st_d.shin = {st_q.shin[14:0], mdio_i};
            end
            if (tick_fall) begin
                if (st_q.pos == pos_t'(LAST_POS)) begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                    if (st_q.is_read) begin
                        st_d.rd_data = st_q.shin;
                        st_d.rd_err  = st_q.ta_bad;
                    end
                end else begin
                    st_d.pos = st_q.pos + pos_t'(1);
                end
            end
        end
        if (st_d.busy)
            {st_d.mdio_oe, st_d.mdio_o} = bit_out(st_d.pos, st_d.frame, st_d.drive);
        else
            {st_d.mdio_oe, st_d.mdio_o} = 2'b01;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.mdio_o <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_w   = st_q.busy;
    assign rd_data  = st_q.rd_data;
    assign done     = st_q.done;
    assign rd_err   = st_q.rd_err;
    assign addr_err = st_q.addr_err;
    assign irq      = st_q.rd_err & irq_en;
    assign mdio_o   = st_q.mdio_o;
    assign mdio_oe  = st_q.mdio_oe;
endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [4:0] phy_addr,
    input logic       irq_en,
    input logic       busy,
    input logic       done,
    input logic       addr_err,
    input logic       irq,
    input logic       mdc,
    input logic       mdio_o,
    input logic       mdio_oe
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    // R2
    mdio_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R6
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    // R8
    rsvd_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && phy_addr == 5'h1F) |=> (done && addr_err && !busy && !mdc));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && mdc) |=> busy);
endmodule

bind mdio_mgmt_master mdio_mgmt_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .phy_addr (phy_addr),
    .irq_en   (irq_en),
    .busy     (busy_w),
    .done     (done),
    .addr_err (addr_err),
    .irq      (irq),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe)
);

// File: tb/tb_mdio_mgmt_master.sv
module tb_mdio_mgmt_master;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 20000;

    typedef struct packed {
        logic        rd;
        logic [4:0]  phy;
        logic [4:0]  rg;
        logic [15:0] wd;
        logic        nopre;
        logic [1:0]  rate;
        logic        ta_bad;
        logic [15:0] rdw;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 5'h01, 5'h00, 16'hA5C3, 1'b0, 2'b00, 1'b0, 16'h0000},
        '{1'b1, 5'h03, 5'h02, 16'h0000, 1'b0, 2'b01, 1'b0, 16'h1234},
        '{1'b0, 5'h1E, 5'h1F, 16'hFFFF, 1'b1, 2'b10, 1'b0, 16'h0000},
        '{1'b1, 5'h00, 5'h1F, 16'h0000, 1'b1, 2'b11, 1'b0, 16'h8001},
        '{1'b1, 5'h05, 5'h04, 16'h0000, 1'b0, 2'b10, 1'b1, 16'hBEEF},
        '{1'b0, 5'h10, 5'h0A, 16'h0001, 1'b1, 2'b00, 1'b0, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd_wr = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wr_data = '0;
    logic        no_preamble = 1'b0;
    logic [1:0]  rate_sel = '0;
    logic        irq_en = 1'b1;
    logic [15:0] rd_data;
    logic        done, rd_err, addr_err, irq, mdc, mdio_o, mdio_oe;
    logic        mdio_i;

    int          checks = 0;
    int          fails  = 0;
    int          rcnt   = 0;
    int          ndrv   = 0;
    logic [63:0] cap    = '0;
    int          m_off  = 0;
    logic        m_ta_bad = 1'b0;
    logic [15:0] m_rdw  = '0;
    int          cyc    = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mdio_mgmt_master dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_wr(rd_wr),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
        .no_preamble(no_preamble), .rate_sel(rate_sel), .irq_en(irq_en),
        .rd_data(rd_data), .done(done), .rd_err(rd_err), .addr_err(addr_err),
        .irq(irq), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model: counts MDC rises, records driven bits, answers reads.
    always @(posedge mdc) begin
        rcnt <= rcnt + 1;
        if (mdio_oe) begin
            cap  <= {cap[62:0], mdio_o};
            ndrv <= ndrv + 1;
        end
    end

    always @* begin
        int idx;
        idx = rcnt + m_off;
        if (idx == 47)                  mdio_i = m_ta_bad;
        else if (idx >= 48 && idx < 64) mdio_i = m_rdw[63 - idx];
        else                            mdio_i = 1'b1;
    end

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int half_of(input logic [1:0] r);
        if (r == 2'b00) return 20;
        if (r == 2'b01) return 10;
        return 5;
    endfunction

    task automatic run_txn(input logic rd, input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] wd, input logic nopre, input logic [1:0] rate,
                           input logic tab, input logic [15:0] rdw, input int glitch_at);
        @(negedge clk);
        rcnt = 0; ndrv = 0; cap = '0;
        m_off = nopre ? 32 : 0; m_ta_bad = tab; m_rdw = rdw;
        rd_wr = rd; phy_addr = phy; reg_addr = rg; wr_data = wd;
        no_preamble = nopre; rate_sel = rate; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < LIMIT) begin
            @(posedge clk); #1;
            cyc++;
            if (cyc == glitch_at) begin
                phy_addr = 5'h07; wr_data = 16'h0F0F; rd_wr = 1'b1; start = 1'b1;
                @(posedge clk); #1;
                cyc++;
                start = 1'b0;
            end
        end
        if (cyc >= LIMIT) chk(1'b0, "watchdog", 64'(cyc), 64'(LIMIT));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk(mdc == 1'b0 && mdio_oe == 1'b0 && done == 1'b0, "R1 reset", {mdc, mdio_oe, done}, 0);
        chk(irq == 1'b0 && rd_err == 1'b0 && addr_err == 1'b0, "R6 reset flags", {irq, rd_err, addr_err}, 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            int nb, hv;
            v  = VEC[i];
            run_txn(v.rd, v.phy, v.rg, v.wd, v.nopre, v.rate, v.ta_bad, v.rdw, 0);
            nb = v.nopre ? 33 : 65;
            hv = half_of(v.rate);
            // R7: frame length
            chk(cyc == nb * 2 * hv, "R7 length", 64'(cyc), 64'(nb * 2 * hv));
            chk(addr_err == 1'b0, "R6 addr_err cleared", 64'(addr_err), 0);
            if (!v.rd) begin
                // R2 / R3: driven bits and preamble
                chk(cap[31:0] == {2'b01, 2'b01, v.phy, v.rg, 2'b10, v.wd}, "R2 write frame",
                    64'(cap[31:0]), 64'({2'b01, 2'b01, v.phy, v.rg, 2'b10, v.wd}));
                chk(ndrv == (v.nopre ? 32 : 64) && (v.nopre || cap[63:32] == '1), "R3 preamble",
                    64'(ndrv), 64'(v.nopre ? 32 : 64));
            end else begin
                // R4: read releases the line after 14 bits
                chk(ndrv == (v.nopre ? 14 : 46) && cap[13:0] == {2'b01, 2'b10, v.phy, v.rg}, "R4 read header",
                    {32'(ndrv), 18'd0, cap[13:0]}, {32'(v.nopre ? 14 : 46), 18'd0, 2'b01, 2'b10, v.phy, v.rg});
                // R5: data
                chk(rd_data == v.rdw, "R5 read data", 64'(rd_data), 64'(v.rdw));
                // R6: turnaround check and interrupt
                chk(rd_err == v.ta_bad && irq == v.ta_bad, "R6 ta check", {rd_err, irq}, {v.ta_bad, v.ta_bad});
            end
            @(posedge clk); #1;
            // R10 and R1 after completion
            chk(done == 1'b0, "R10 done pulse", 64'(done), 0);
            chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 idle after frame", {mdc, mdio_oe}, 0);
        end

        // R8: reserved PHY address is refused
        run_txn(1'b0, 5'h1F, 5'h03, 16'h1111, 1'b0, 2'b10, 1'b0, 16'h0, 0);
        chk(cyc == 0 && addr_err == 1'b1, "R8 reserved addr", {32'(cyc), 31'd0, addr_err}, {32'd0, 32'd1});
        repeat (40) @(posedge clk); #1;
        chk(rcnt == 0 && mdc == 1'b0, "R8 no mdc activity", 64'(rcnt), 0);

        // R6: masked interrupt, flag still visible, unmask reveals it
        irq_en = 1'b0;
        run_txn(1'b1, 5'h02, 5'h01, 16'h0, 1'b1, 2'b10, 1'b1, 16'h5A5A, 0);
        chk(rd_err == 1'b1 && irq == 1'b0 && addr_err == 1'b0, "R6 masked irq", {rd_err, irq, addr_err}, 64'b100);
        @(negedge clk); irq_en = 1'b1; #1;
        chk(irq == 1'b1, "R6 unmasked irq", 64'(irq), 1);

        // R9: start while busy ignored
        run_txn(1'b0, 5'h02, 5'h09, 16'hC0DE, 1'b1, 2'b10, 1'b0, 16'h0, 100);
        chk(cyc == 33 * 2 * 5, "R9 length unchanged", 64'(cyc), 64'(33 * 2 * 5));
        chk(cap[31:0] == {2'b01, 2'b01, 5'h02, 5'h09, 2'b10, 16'hC0DE}, "R9 frame unchanged",
            64'(cap[31:0]), 64'({2'b01, 2'b01, 5'h02, 5'h09, 2'b10, 16'hC0DE}));
        chk(rd_err == 1'b0 && irq == 1'b0, "R6 flag cleared on start", {rd_err, irq}, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule